// File: doc/BRIEF.md
# AC'97 Codec Register Access Engine

This block carries register reads and writes between a host and an AC'97 codec over the command and status slots of the serial frame. The host loads the data word first. It then loads the command word, which holds the register index, a read flag and the codec number. Loading the command is the act that queues the transfer. On the next frame start, the command word goes out in slot 1 if slot 1 transmit is enabled. The data word goes out in slot 2 of that same frame, but only if slot 2 transmit is enabled and slot 1 is also being sent.

Each command slot has its own busy flag. The flag stays set until that slot has gone out in a frame. On the receive side, incoming slot 1 and slot 2 words are held in per-slot status registers, each with a valid flag. A held word is never overwritten while its flag is set; an arrival at that time sets a sticky overrun flag instead. Reading a status register clears its valid flag. A read reply is complete when both status slots are valid. The returned register index and data are taken from fixed bit fields of the held words.

The frame timing comes from outside the block, as a one-cycle pulse at each frame start. At 48 kHz frames, a codec reply normally arrives within about two frames.

Top module: `codec_reg_engine`

## Requirements
- R1: After reset, both busy flags, both transmit tags, both valid flags, both overrun flags and read_done are 0. Both transmit words, tx_codec, sts_addr and sts_data are also 0.
- R2: A cmd_load pulse builds the slot 1 word from its fields and sets slot1_busy. The word has cmd_read at bit 19, cmd_addr at bits 18:12 and zeros in bits 11:0. The pulse also latches cmd_codec for that command.
- R3: A data_load pulse stores data_word at bits 19:4 of the slot 2 word, with zeros in bits 3:0, and sets slot2_busy.
- R4: On a frame_tick, slot 1 is launched when slot1_busy and slot1_tx_en are both 1. Launching registers tx_slot1_tag=1 and the word, and clears slot1_busy. Otherwise tx_slot1_tag and tx_slot1_word become 0 and slot1_busy holds. The transmit outputs change only on frame_tick.
- R5: Slot 2 is launched on a frame_tick only when slot2_busy and slot2_tx_en are both 1 and slot 1 launches on that same tick. Otherwise tx_slot2_tag and tx_slot2_word become 0 and slot2_busy holds.
- R6: On a tick that launches slot 1, tx_codec shows the codec number latched with that command; on any other tick it becomes 0.
- R7: A load and a frame_tick in the same cycle: the tick sends the previously held word, and the new word is held with busy set.
- R8: When rx_strobe is 1 with a slot tag of 1 and that slot's valid flag is 0, the slot word is captured and the valid flag is set.
- R9: When a slot tag arrives while that slot's valid flag is 1 and it is not being read, the held word is unchanged and the sticky overrun flag is set until reset.
- R10: A read pulse clears that slot's valid flag. If a tagged word arrives in the same cycle, the word is captured and valid stays 1 with no overrun.
- R11: An rx_strobe with a slot tag of 0 leaves that slot's held word, valid flag and overrun flag unchanged.
- R12: read_done is 1 exactly when both valid flags are 1. sts_addr is bits 18:12 of the held slot 1 word, and sts_data is bits 19:4 of the held slot 2 word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_tick | input | 1 | One-cycle pulse at each frame start |
| slot1_tx_en | input | 1 | Slot 1 transmit enable |
| slot2_tx_en | input | 1 | Slot 2 transmit enable |
| cmd_load | input | 1 | Load the command word and queue the transfer |
| cmd_addr | input | 7 | Codec register index |
| cmd_read | input | 1 | 1 for a read request |
| cmd_codec | input | 2 | Codec number for this command |
| data_load | input | 1 | Load the slot 2 data word |
| data_word | input | 16 | Register write data |
| tx_slot1_word | output | 20 | Slot 1 word for the current frame |
| tx_slot1_tag | output | 1 | Slot 1 carries a valid word this frame |
| tx_slot2_word | output | 20 | Slot 2 word for the current frame |
| tx_slot2_tag | output | 1 | Slot 2 carries a valid word this frame |
| tx_codec | output | 2 | Codec addressed by this frame's command |
| slot1_busy | output | 1 | Slot 1 word waiting to be sent |
| slot2_busy | output | 1 | Slot 2 word waiting to be sent |
| rx_strobe | input | 1 | A received frame's status slots are present |
| rx_slot1_tag | input | 1 | Received slot 1 is valid |
| rx_slot1_word | input | 20 | Received slot 1 word |
| rx_slot2_tag | input | 1 | Received slot 2 is valid |
| rx_slot2_word | input | 20 | Received slot 2 word |
| sts1_read | input | 1 | Host reads status slot 1 |
| sts2_read | input | 1 | Host reads status slot 2 |
| sts1_valid | output | 1 | Status slot 1 holds an unread word |
| sts2_valid | output | 1 | Status slot 2 holds an unread word |
| sts1_overrun | output | 1 | Sticky: slot 1 word arrived while still valid |
| sts2_overrun | output | 1 | Sticky: slot 2 word arrived while still valid |
| sts_addr | output | 7 | Returned register index |
| sts_data | output | 16 | Returned register data |
| read_done | output | 1 | Both status slots valid |

## Verification
The bench runs a register write with both enables set and checks that both slots go out in one frame. It runs a read request to show that a stale slot 2 is not sent alongside it. It then queues slot 2 alone, which must wait for a slot 1 launch. Runs with each enable cleared separate the slot 1 gating from the slot 2 gating, and a load that coincides with a tick shows which word the tick sends. On the receive side, the bench uses tagged and untagged arrivals, arrivals into a full slot, and a read that coincides with an arrival. These distinguish capture, overrun, ignore and the read-clear priority.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  localparam int SLOT_W  = 20;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 16;
  localparam int ADDR_LO = 12;
  localparam int DATA_LO = 4;
  localparam int RD_BIT  = 19;

  function automatic logic [SLOT_W-1:0] pack_cmd(input logic [ADDR_W-1:0] addr, input logic rd);
    logic [SLOT_W-1:0] w;
    w = '0;
    w[ADDR_LO +: ADDR_W] = addr;
    w[RD_BIT] = rd;
    return w;
  endfunction

  function automatic logic [SLOT_W-1:0] pack_data(input logic [DATA_W-1:0] d);
    logic [SLOT_W-1:0] w;
    w = '0;
    w[DATA_LO +: DATA_W] = d;
    return w;
  endfunction
endpackage

// File: rtl/cmd_slot_tx.sv
module cmd_slot_tx #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         tick,
  input  logic         enable,
  input  logic         gate,
  output logic         ready,
  output logic         busy,
  output logic         tag,
  output logic [W-1:0] word
);
  logic [W-1:0] hold;

  assign ready = busy & enable & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      busy <= 1'b0;
      tag  <= 1'b0;
      word <= '0;
    end else begin
      if (tick) begin
        tag  <= ready;
        word <= ready ? hold : '0;
        if (ready) busy <= 1'b0;
      end
      if (load) begin
        hold <= load_word;
        busy <= 1'b1;
      end
    end
  end

  AST_TX_STABLE_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(tag) && $stable(word))); // R4
  AST_TX_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready) |=> busy); // R4
endmodule

// File: rtl/status_slot_rx.sv
module status_slot_rx #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         slot_tag,
  input  logic [W-1:0] slot_word,
  input  logic         rd,
  output logic         valid,
  output logic         overrun,
  output logic [W-1:0] held
);
  logic arrive, capture;

  assign arrive  = strobe & slot_tag;
  assign capture = arrive & (~valid | rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
      held    <= '0;
    end else begin
      if (capture) begin
        held  <= slot_word;
        valid <= 1'b1;
      end else if (rd) begin
        valid <= 1'b0;
      end
      if (arrive && !capture) overrun <= 1'b1;
    end
  end

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R9
  AST_FULL_HELD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !rd) |=> (valid && $stable(held))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !arrive) |=> !valid); // R10
endmodule

// File: rtl/codec_reg_engine.sv
module codec_reg_engine
  import codec_reg_pkg::*;
#(
  parameter int CODEC_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_tick,
  input  logic               slot1_tx_en,
  input  logic               slot2_tx_en,
  input  logic               cmd_load,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic               cmd_read,
  input  logic [CODEC_W-1:0] cmd_codec,
  input  logic               data_load,
  input  logic [DATA_W-1:0]  data_word,
  output logic [SLOT_W-1:0]  tx_slot1_word,
  output logic               tx_slot1_tag,
  output logic [SLOT_W-1:0]  tx_slot2_word,
  output logic               tx_slot2_tag,
  output logic [CODEC_W-1:0] tx_codec,
  output logic               slot1_busy,
  output logic               slot2_busy,
  input  logic               rx_strobe,
  input  logic               rx_slot1_tag,
  input  logic [SLOT_W-1:0]  rx_slot1_word,
  input  logic               rx_slot2_tag,
  input  logic [SLOT_W-1:0]  rx_slot2_word,
  input  logic               sts1_read,
  input  logic               sts2_read,
  output logic               sts1_valid,
  output logic               sts2_valid,
  output logic               sts1_overrun,
  output logic               sts2_overrun,
  output logic [ADDR_W-1:0]  sts_addr,
  output logic [DATA_W-1:0]  sts_data,
  output logic               read_done
);
  logic               launch1, launch2;
  logic [CODEC_W-1:0] codec_hold;
  logic [SLOT_W-1:0]  held1, held2;
  logic               unused_held_bits;

  cmd_slot_tx #(.W(SLOT_W)) u_tx1 (
    .clk(clk), .rst_n(rst_n), .load(cmd_load),
    .load_word(pack_cmd(cmd_addr, cmd_read)), .tick(frame_tick),
    .enable(slot1_tx_en), .gate(1'b1), .ready(launch1),
    .busy(slot1_busy), .tag(tx_slot1_tag), .word(tx_slot1_word));

  cmd_slot_tx #(.W(SLOT_W)) u_tx2 (
    .clk(clk), .rst_n(rst_n), .load(data_load),
    .load_word(pack_data(data_word)), .tick(frame_tick),
    .enable(slot2_tx_en), .gate(launch1), .ready(launch2),
    .busy(slot2_busy), .tag(tx_slot2_tag), .word(tx_slot2_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      codec_hold <= '0;
      tx_codec   <= '0;
    end else begin
      if (frame_tick) tx_codec <= launch1 ? codec_hold : '0;
      if (cmd_load) codec_hold <= cmd_codec;
    end
  end

  status_slot_rx #(.W(SLOT_W)) u_rx1 (
    .clk(clk), .rst_n(rst_n), .strobe(rx_strobe), .slot_tag(rx_slot1_tag),
    .slot_word(rx_slot1_word), .rd(sts1_read), .valid(sts1_valid),
    .overrun(sts1_overrun), .held(held1));

  status_slot_rx #(.W(SLOT_W)) u_rx2 (
    .clk(clk), .rst_n(rst_n), .strobe(rx_strobe), .slot_tag(rx_slot2_tag),
    .slot_word(rx_slot2_word), .rd(sts2_read), .valid(sts2_valid),
    .overrun(sts2_overrun), .held(held2));

  assign sts_addr  = held1[ADDR_LO +: ADDR_W];
  assign sts_data  = held2[DATA_LO +: DATA_W];
  assign read_done = sts1_valid & sts2_valid;
  assign unused_held_bits = ^{held1[SLOT_W-1:ADDR_LO+ADDR_W], held1[ADDR_LO-1:0], held2[DATA_LO-1:0]};

  AST_SLOT2_NEEDS_SLOT1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_slot2_tag |-> tx_slot1_tag); // R5
  AST_LAUNCH_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && launch1 && !cmd_load) |=> (!slot1_busy && tx_slot1_tag)); // R4
  AST_CODEC_ONLY_WITH_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_slot1_tag |-> (tx_codec == '0)); // R6
endmodule

// File: tb/test_codec_reg_engine.sv
module test_codec_reg_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic frame_tick = 0, en1 = 0, en2 = 0, cmd_load = 0, cmd_read = 0, data_load = 0;
  logic [6:0] cmd_addr = '0;
  logic [1:0] cmd_codec = '0;
  logic [15:0] data_word = '0;
  logic rx_strobe = 0, rx_tag1 = 0, rx_tag2 = 0, rd1 = 0, rd2 = 0;
  logic [19:0] rx_w1 = '0, rx_w2 = '0;

  logic [19:0] tx_w1, tx_w2;
  logic tx_t1, tx_t2, busy1, busy2, v1, v2, o1, o2, done;
  logic [1:0] tx_codec;
  logic [6:0] sts_addr;
  logic [15:0] sts_data;

  codec_reg_engine i_codec_reg_engine (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .slot1_tx_en(en1), .slot2_tx_en(en2),
    .cmd_load(cmd_load), .cmd_addr(cmd_addr), .cmd_read(cmd_read), .cmd_codec(cmd_codec),
    .data_load(data_load), .data_word(data_word),
    .tx_slot1_word(tx_w1), .tx_slot1_tag(tx_t1), .tx_slot2_word(tx_w2), .tx_slot2_tag(tx_t2),
    .tx_codec(tx_codec), .slot1_busy(busy1), .slot2_busy(busy2),
    .rx_strobe(rx_strobe), .rx_slot1_tag(rx_tag1), .rx_slot1_word(rx_w1),
    .rx_slot2_tag(rx_tag2), .rx_slot2_word(rx_w2),
    .sts1_read(rd1), .sts2_read(rd2), .sts1_valid(v1), .sts2_valid(v2),
    .sts1_overrun(o1), .sts2_overrun(o2), .sts_addr(sts_addr), .sts_data(sts_data),
    .read_done(done));

  // Behavioural reference model
  int m_busy1 = 0, m_busy2 = 0, m_tag1 = 0, m_tag2 = 0, m_word1 = 0, m_word2 = 0;
  int m_hold1 = 0, m_hold2 = 0, m_chold = 0, m_codec = 0;
  int m_v1 = 0, m_v2 = 0, m_o1 = 0, m_o2 = 0, m_h1 = 0, m_h2 = 0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy1 = 0; m_busy2 = 0; m_tag1 = 0; m_tag2 = 0; m_word1 = 0; m_word2 = 0;
      m_hold1 = 0; m_hold2 = 0; m_chold = 0; m_codec = 0;
      m_v1 = 0; m_v2 = 0; m_o1 = 0; m_o2 = 0; m_h1 = 0; m_h2 = 0;
    end else begin
      int go1, go2;
      go1 = (m_busy1 != 0 && en1) ? 1 : 0;
      go2 = (m_busy2 != 0 && en2 && go1 != 0) ? 1 : 0;
      if (frame_tick) begin  // R4 R5 R6
        m_tag1 = go1; m_word1 = go1 ? m_hold1 : 0;
        m_tag2 = go2; m_word2 = go2 ? m_hold2 : 0;
        m_codec = go1 ? m_chold : 0;
        if (go1) m_busy1 = 0;
        if (go2) m_busy2 = 0;
      end
      if (cmd_load) begin  // R2 R7
        m_hold1 = int'(cmd_read) * 524288 + int'(cmd_addr) * 4096;
        m_busy1 = 1; m_chold = int'(cmd_codec);
      end
      if (data_load) begin  // R3
        m_hold2 = int'(data_word) * 16; m_busy2 = 1;
      end
      if (rx_strobe && rx_tag1) begin  // R8 R9 R10
        if (m_v1 == 0 || rd1) begin m_h1 = int'(rx_w1); m_v1 = 1; end
        else m_o1 = 1;
      end else if (rd1) m_v1 = 0;
      if (rx_strobe && rx_tag2) begin
        if (m_v2 == 0 || rd2) begin m_h2 = int'(rx_w2); m_v2 = 1; end
        else m_o2 = 1;
      end else if (rd2) m_v2 = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2", "slot1_busy", int'(busy1), m_busy1);
    chk("R3", "slot2_busy", int'(busy2), m_busy2);
    chk("R4", "tx_slot1_tag", int'(tx_t1), m_tag1);
    chk("R4", "tx_slot1_word", int'(tx_w1), m_word1);
    chk("R5", "tx_slot2_tag", int'(tx_t2), m_tag2);
    chk("R5", "tx_slot2_word", int'(tx_w2), m_word2);
    chk("R6", "tx_codec", int'(tx_codec), m_codec);
    chk("R8", "sts1_valid", int'(v1), m_v1);
    chk("R8", "sts2_valid", int'(v2), m_v2);
    chk("R9", "sts1_overrun", int'(o1), m_o1);
    chk("R9", "sts2_overrun", int'(o2), m_o2);
    chk("R12", "read_done", int'(done), (m_v1 != 0 && m_v2 != 0) ? 1 : 0);
    chk("R12", "sts_addr", int'(sts_addr), (m_h1 / 4096) % 128);
    chk("R12", "sts_data", int'(sts_data), (m_h2 / 16) % 65536);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_tick = 0; cmd_load = 0; data_load = 0; rx_strobe = 0; rd1 = 0; rd2 = 0;
    end
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1; idle(1);
  endtask

  task automatic load_cmd(input logic [6:0] a, input logic r, input logic [1:0] c);
    @(negedge clk); cmd_load = 1; cmd_addr = a; cmd_read = r; cmd_codec = c; idle(1);
  endtask

  task automatic load_data(input logic [15:0] d);
    @(negedge clk); data_load = 1; data_word = d; idle(1);
  endtask

  task automatic rx(input logic t1, input logic [19:0] w1, input logic t2, input logic [19:0] w2);
    @(negedge clk); rx_strobe = 1; rx_tag1 = t1; rx_w1 = w1; rx_tag2 = t2; rx_w2 = w2; idle(1);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state checked each cycle while reset held
    @(negedge clk); rst_n = 1; idle(2);
    en1 = 1; en2 = 1;
    // write: data then command, both sent in one frame (R2 R3 R4 R5 R6)
    load_data(16'hBEEF); load_cmd(7'h2C, 1'b0, 2'd1); idle(2); tick(); idle(3);
    tick(); idle(2);
    // read request: slot 2 idle so not sent (R5)
    load_cmd(7'h7E, 1'b1, 2'd3); tick(); idle(2);
    // slot 1 disabled holds busy (R4)
    en1 = 0; load_cmd(7'h11, 1'b0, 2'd2); load_data(16'h1234); tick(); idle(2);
    en1 = 1; tick(); idle(2);
    // slot 2 alone waits for slot 1 (R5)
    load_data(16'h00A5); tick(); tick(); load_cmd(7'h05, 1'b1, 2'd0); tick(); idle(2);
    // slot 2 disabled (R5)
    en2 = 0; load_data(16'hFFFF); load_cmd(7'h40, 1'b0, 2'd1); tick(); idle(1);
    en2 = 1; tick(); load_cmd(7'h22, 1'b0, 2'd2); tick(); idle(2);
    // load coincident with tick (R7)
    load_cmd(7'h33, 1'b0, 2'd1);
    @(negedge clk); frame_tick = 1; cmd_load = 1; cmd_addr = 7'h44; cmd_codec = 2'd2; idle(1);
    tick(); idle(2);
    // receive (R8 R12)
    rx(1'b1, 20'h26000, 1'b1, 20'h5A5A0); idle(2);
    // arrival into full slots (R9)
    rx(1'b1, 20'h7F000, 1'b1, 20'h11110); idle(2);
    // read clears (R10), untagged ignored (R11)
    @(negedge clk); rd1 = 1; idle(1);
    rx(1'b0, 20'h3C000, 1'b0, 20'h22220); idle(2);
    rx(1'b1, 20'h0A000, 1'b0, 20'h0); idle(2);
    // read with coincident arrival (R10)
    @(negedge clk); rd2 = 1; rx_strobe = 1; rx_tag1 = 0; rx_tag2 = 1; rx_w2 = 20'hCAFE0; idle(2);
    @(negedge clk); rd1 = 1; rd2 = 1; idle(3);
    // reset again mid-activity (R1)
    load_cmd(7'h01, 1'b1, 2'd1);
    @(negedge clk); rst_n = 0; idle(2);
    @(negedge clk); rst_n = 1; idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule